// File: doc/BRIEF.md
# Host Wake-Request Power Handshake Controller

This block keeps track of whether an internal processor domain is powered and clocked, so that a host can tell when internal resources may be reached. The host drives the block through a small word-addressed register port. One control/status word carries two host-owned bits, init-done and access-request, and four status fields: clock-ready, going-to-sleep, the power-save type, and a live mirror of an external RF-kill switch. A second word takes a self-clearing software reset command.

The domain's power-up is modelled as a wake latency of N cycles, with N taken from an input. Power-down is a fixed warning window of M cycles, set by a parameter, during which going-to-sleep is raised before clock-ready drops. An internal sleep request starts a power-down only when the host is not holding the access request. The request carries a kind code that selects the power-save type reported while the domain sleeps. The access-allowed output is true only while the domain is clocked and not about to sleep.

Top module: `pwr_handshake_ctrl`

## Requirements
- R1: After reset, the control/status word (word offset 0) reads 0x00000000 and access_ok_o is 0. Clock-ready (bit 0) stays 0 while init-done (bit 2) has been 0 at the previous clock edge.
- R2: Suppose the write that sets init-done takes effect at edge k, from the off state. Or suppose the write that sets access-request (bit 3) takes effect at edge k while the domain is asleep. In either case, clock-ready reads 1 right after edge k+N+1 and 0 before it, with N = wake_lat_i. N = 0 behaves like N = 1.
- R3: access_ok_o is 1 exactly when clock-ready is 1 and going-to-sleep (bit 4) is 0.
- R4: A sleep request sampled at edge j while awake, with access-request 0, raises going-to-sleep from edge j to edge j+M. Clock-ready stays 1 during that window and drops at edge j+M. A sleep request sampled while access-request is 1 has no effect.
- R5: If access-request is set while going-to-sleep is 1, the domain returns to awake one edge after the write: going-to-sleep clears and clock-ready stays 1.
- R6: While asleep, bits 26:24 report the power-save type chosen by sleep_kind_i at the sleep request: kind 0 gives 001 (processor power-down), kind 1 gives 010 (radio power-down), kinds 2 and 3 give 011 (error). The field reads 000 in every other state.
- R7: Writing init-done to 0 drops clock-ready one edge after the write takes effect, and the domain returns to low power.
- R8: Writing word offset 1 with bit 7 set clears init-done and access-request, forces the power-save type to 000 and drops clock-ready at that same edge. Writes to offset 1 with bit 7 clear have no effect. Offset 1 reads 0.
- R9: Bit 27 of the control/status word follows rf_kill_i in the same cycle.
- R10: Bits 0, 4, 24 to 27 and every other bit of word 0 except bits 2 and 3 are read-only. Writing 1 to them has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address (0 control/status, 1 reset command) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed word, combinational |
| rf_kill_i | input | 1 | External RF-kill switch level |
| sleep_req_i | input | 1 | Internal request to power the domain down |
| sleep_kind_i | input | 2 | Kind code that selects the power-save type |
| wake_lat_i | input | CNT_W | Wake latency N in cycles |
| access_ok_o | output | 1 | Internal access allowed |

## Verification
A wrong state in the power sequencer shows up on the clock-ready and going-to-sleep bits and on access_ok_o within one edge. The bench therefore samples those bits one cycle before and one cycle after every expected transition. An off-by-one in the wake or sleep counter moves the clock-ready edge by a cycle, so it appears at the boundary checks with N = 0, N = 1 and N = 5. A wrongly held power-save type or a sleep request that should have been ignored shows up in bits 26:24 or in bit 0 within M cycles of the request.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int DATA_W = 32;

  localparam int B_CLK_RDY = 0;
  localparam int B_INIT    = 2;
  localparam int B_ACC_REQ = 3;
  localparam int B_GOING   = 4;
  localparam int B_PT_LO   = 24;
  localparam int B_RFKILL  = 27;
  localparam int B_SW_RST  = 7;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAKE,
    ST_AWAKE,
    ST_DOZE,
    ST_ASLEEP
  } pwr_state_e;

  function automatic logic [2:0] kind_to_ptype(logic [1:0] kind);
    case (kind)
      2'd0:    return 3'b001;
      2'd1:    return 3'b010;
      default: return 3'b011;
    endcase
  endfunction
endpackage

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2 / R4: window counter never wraps
  a_r2_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !load_i |-> cnt_q != '0);
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import hs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SLEEP_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_done_i,
  input  logic             access_req_i,
  input  logic             sw_rst_i,
  input  logic             sleep_req_i,
  input  logic [1:0]       sleep_kind_i,
  input  logic [CNT_W-1:0] wake_lat_i,
  output logic             clk_ready_o,
  output logic             going_sleep_o,
  output logic [2:0]       ptype_o
);
  localparam logic [CNT_W-1:0] DOZE_LOAD = CNT_W'(SLEEP_CYC - 1);

  pwr_state_e       state_q, state_d;
  logic [1:0]       kind_q;
  logic [2:0]       ptype_q;
  logic             t_load, t_dec, t_zero;
  logic [CNT_W-1:0] t_val, wake_load;

  assign wake_load = (wake_lat_i == '0) ? '0 : wake_lat_i - 1'b1;

  hs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .dec_i      (t_dec),
    .zero_o     (t_zero)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_dec   = 1'b0;
    t_val   = wake_load;
    unique case (state_q)
      ST_OFF: if (init_done_i) begin
        state_d = ST_WAKE;
        t_load  = 1'b1;
      end
      ST_WAKE: begin
        if (!init_done_i) state_d = ST_OFF;
        else if (t_zero)  state_d = ST_AWAKE;
        else              t_dec   = 1'b1;
      end
      ST_AWAKE: begin
        if (!init_done_i) state_d = ST_OFF;
        else if (sleep_req_i && !access_req_i) begin
          state_d = ST_DOZE;
          t_load  = 1'b1;
          t_val   = DOZE_LOAD;
        end
      end
      ST_DOZE: begin
        if (!init_done_i)      state_d = ST_OFF;
        else if (access_req_i) state_d = ST_AWAKE;
        else if (t_zero)       state_d = ST_ASLEEP;
        else                   t_dec   = 1'b1;
      end
      ST_ASLEEP: begin
        if (!init_done_i) state_d = ST_OFF;
        else if (access_req_i) begin
          state_d = ST_WAKE;
          t_load  = 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
    if (sw_rst_i) begin
      state_d = ST_OFF;
      t_load  = 1'b0;
      t_dec   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      kind_q  <= '0;
      ptype_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_AWAKE && state_d == ST_DOZE) kind_q <= sleep_kind_i;
      if (state_d != ST_ASLEEP)     ptype_q <= 3'b000;
      else if (state_q == ST_DOZE)  ptype_q <= kind_to_ptype(kind_q);
    end
  end

  assign clk_ready_o   = (state_q == ST_AWAKE) || (state_q == ST_DOZE);
  assign going_sleep_o = (state_q == ST_DOZE);
  assign ptype_o       = ptype_q;

  // R1 / R7: no clock-ready once init-done was low at the previous edge
  a_r7_off_without_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(init_done_i) |-> !clk_ready_o);
  // R4: sleep warning only starts without an access request
  a_r4_sleep_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(going_sleep_o) |-> !$past(access_req_i));
  // R4: warning window stays clocked
  a_r4_going_clocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    going_sleep_o |-> clk_ready_o);
  // R5: held access request keeps the domain awake
  a_r5_keep_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(access_req_i) && $past(init_done_i) && $past(clk_ready_o) && !$past(sw_rst_i)
    |-> clk_ready_o && !going_sleep_o);
  // R6: power-save type nonzero only while unclocked
  a_r6_ptype_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptype_o != 3'b000 |-> !clk_ready_o);
endmodule

// File: rtl/hs_regs.sv
module hs_regs
  import hs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clk_ready_i,
  input  logic              going_sleep_i,
  input  logic [2:0]        ptype_i,
  input  logic              rf_kill_i,
  output logic              init_done_o,
  output logic              access_req_o,
  output logic              sw_rst_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(1);

  logic init_q, acc_q, ctrl_we;
  logic wdata_unused;

  assign wdata_unused = ^{wdata_i[DATA_W-1:8], wdata_i[6:4], wdata_i[1:0]};
  assign ctrl_we  = we_i && (addr_i == A_CTRL);
  assign sw_rst_o = we_i && (addr_i == A_RST) && wdata_i[B_SW_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      acc_q  <= 1'b0;
    end else if (sw_rst_o) begin
      init_q <= 1'b0;
      acc_q  <= 1'b0;
    end else if (ctrl_we) begin
      init_q <= wdata_i[B_INIT];
      acc_q  <= wdata_i[B_ACC_REQ];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[B_CLK_RDY]          = clk_ready_i;
      rdata_o[B_INIT]             = init_q;
      rdata_o[B_ACC_REQ]          = acc_q;
      rdata_o[B_GOING]            = going_sleep_i;
      rdata_o[B_PT_LO+2:B_PT_LO]  = ptype_i;
      rdata_o[B_RFKILL]           = rf_kill_i;
    end
  end

  assign init_done_o  = init_q;
  assign access_req_o = acc_q;

  // R8: reset command clears both host bits
  a_r8_rst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o |=> !init_done_o && !access_req_o);
  // R10: host bits change only through a write
  a_r10_bits_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> $stable(init_done_o) && $stable(access_req_o));
endmodule

// File: rtl/pwr_handshake_ctrl.sv
module pwr_handshake_ctrl
  import hs_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 8,
  parameter int SLEEP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              rf_kill_i,
  input  logic              sleep_req_i,
  input  logic [1:0]        sleep_kind_i,
  input  logic [CNT_W-1:0]  wake_lat_i,
  output logic              access_ok_o
);
  logic       init_done, access_req, sw_rst;
  logic       clk_ready, going_sleep;
  logic [2:0] ptype;

  hs_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .clk_ready_i   (clk_ready),
    .going_sleep_i (going_sleep),
    .ptype_i       (ptype),
    .rf_kill_i     (rf_kill_i),
    .init_done_o   (init_done),
    .access_req_o  (access_req),
    .sw_rst_o      (sw_rst),
    .rdata_o       (reg_rdata_o)
  );

  hs_fsm #(.CNT_W(CNT_W), .SLEEP_CYC(SLEEP_CYC)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .init_done_i   (init_done),
    .access_req_i  (access_req),
    .sw_rst_i      (sw_rst),
    .sleep_req_i   (sleep_req_i),
    .sleep_kind_i  (sleep_kind_i),
    .wake_lat_i    (wake_lat_i),
    .clk_ready_o   (clk_ready),
    .going_sleep_o (going_sleep),
    .ptype_o       (ptype)
  );

  assign access_ok_o = clk_ready && !going_sleep;

  // R3: access only when clocked and not about to sleep
  a_r3_ok_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_ok_o |-> reg_rdata_o[B_CLK_RDY] || (reg_addr_i != '0));
  // R8: reset command drops clock-ready at once
  a_r8_rst_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst |=> !access_ok_o);
endmodule

// File: tb/pwr_handshake_ctrl_tb_top.sv
module pwr_handshake_ctrl_tb_top;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 8;
  localparam int M      = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rf_kill = 1'b0;
  logic              sleep_req = 1'b0;
  logic [1:0]        kind = '0;
  logic [CNT_W-1:0]  wlat = 8'd5;
  logic              ok;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] mask;
    logic [31:0] exp;
    logic        exp_ok;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  always #2 clk = ~clk;

  pwr_handshake_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLEEP_CYC(M)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reg_we_i     (we),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .rf_kill_i    (rf_kill),
    .sleep_req_i  (sleep_req),
    .sleep_kind_i (kind),
    .wake_lat_i   (wlat),
    .access_ok_o  (ok)
  );

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      n_checks++;
      if (((rdata & it.mask) !== it.exp) || (ok !== it.exp_ok)) begin
        n_err++;
        $display("FAIL %s: rdata=%h ok=%0b expected rdata=%h ok=%0b (mask %h)",
                 it.tag, rdata & it.mask, ok, it.exp, it.exp_ok, it.mask);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic expect_w0(input logic [31:0] mask, input logic [31:0] exp,
                           input logic exp_ok, input string tag);
    sb_item_t it;
    addr = '0;
    it.mask = mask; it.exp = exp; it.exp_ok = exp_ok; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic sleep_pulse(input logic [1:0] k);
    sleep_req = 1'b1; kind = k;
    @(posedge clk); #1;
    sleep_req = 1'b0;
  endtask

  task automatic wake_up();
    wr(0, 32'h0000_000C);
    repeat (6) tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    expect_w0(32'hFFFF_FFFF, 32'h0, 1'b0, "R1 reset state");
    tick();
    expect_w0(32'h0000_0001, 32'h0, 1'b0, "R1 ready low before init");

    wr(0, 32'h0F00_0011);
    expect_w0(32'hFFFF_FFFF, 32'h0, 1'b0, "R10 status bits read-only");

    // init-done wake, N=5
    wr(0, 32'h0000_0004);
    repeat (5) tick();
    expect_w0(32'h0000_001F, 32'h0000_0004, 1'b0, "R2 ready not before N+1");
    tick();
    expect_w0(32'h0000_001F, 32'h0000_0005, 1'b1, "R2 ready after N+1");

    // sleep kind 0
    sleep_pulse(2'd0);
    expect_w0(32'h0000_001F, 32'h0000_0015, 1'b0, "R3 going blocks access");
    repeat (M - 1) tick();
    expect_w0(32'h0700_001F, 32'h0000_0015, 1'b0, "R4 going lasts M");
    tick();
    expect_w0(32'h0700_001F, 32'h0100_0004, 1'b0, "R6 processor power-down 001");

    // wake from asleep via access request
    wr(0, 32'h0000_000C);
    repeat (5) tick();
    expect_w0(32'h0700_001F, 32'h0000_000C, 1'b0, "R2 asleep wake not early");
    tick();
    expect_w0(32'h0700_001F, 32'h0000_000D, 1'b1, "R2 asleep wake at N+1");

    // sleep request ignored while access held
    sleep_pulse(2'd0);
    repeat (M) tick();
    expect_w0(32'h0700_001F, 32'h0000_000D, 1'b1, "R4 sleep ignored with access");

    // radio kind
    wr(0, 32'h0000_0004);
    sleep_pulse(2'd1);
    repeat (M) tick();
    expect_w0(32'h0700_001F, 32'h0200_0004, 1'b0, "R6 radio power-down 010");

    // error kinds
    wake_up();
    wr(0, 32'h0000_0004);
    sleep_pulse(2'd2);
    repeat (M) tick();
    expect_w0(32'h0700_001F, 32'h0300_0004, 1'b0, "R6 kind 2 error 011");
    wake_up();
    wr(0, 32'h0000_0004);
    sleep_pulse(2'd3);
    repeat (M) tick();
    expect_w0(32'h0700_001F, 32'h0300_0004, 1'b0, "R6 kind 3 error 011");

    // abort sleep with access request
    wake_up();
    wr(0, 32'h0000_0004);
    sleep_pulse(2'd0);
    tick();
    wr(0, 32'h0000_000C);
    tick();
    expect_w0(32'h0700_001F, 32'h0000_000D, 1'b1, "R5 sleep aborted");
    repeat (M + 1) tick();
    expect_w0(32'h0700_001F, 32'h0000_000D, 1'b1, "R5 stays awake");

    // RF-kill mirror
    rf_kill = 1'b1; #1;
    expect_w0(32'h0800_0000, 32'h0800_0000, 1'b1, "R9 rf-kill high");
    rf_kill = 1'b0; #1;
    expect_w0(32'h0800_0000, 32'h0000_0000, 1'b1, "R9 rf-kill low");

    // clear init-done
    wr(0, 32'h0000_0000);
    expect_w0(32'h0000_001F, 32'h0000_0001, 1'b1, "R7 ready one edge later");
    tick();
    expect_w0(32'h0700_001F, 32'h0000_0000, 1'b0, "R7 ready dropped");

    // N = 1 and N = 0 boundaries
    wlat = 8'd1;
    wr(0, 32'h0000_0004);
    tick();
    expect_w0(32'h0000_0001, 32'h0, 1'b0, "R2 N=1 not early");
    tick();
    expect_w0(32'h0000_0001, 32'h1, 1'b1, "R2 N=1 ready");
    wr(0, 32'h0000_0000);
    tick();
    wlat = 8'd0;
    wr(0, 32'h0000_0004);
    tick();
    expect_w0(32'h0000_0001, 32'h0, 1'b0, "R2 N=0 not early");
    tick();
    expect_w0(32'h0000_0001, 32'h1, 1'b1, "R2 N=0 acts as 1");
    wlat = 8'd5;

    // software reset while asleep
    sleep_pulse(2'd0);
    repeat (M) tick();
    wr(1, 32'h0000_007F);
    expect_w0(32'h0700_001F, 32'h0100_0004, 1'b0, "R8 reset without bit 7 ignored");
    wr(1, 32'h0000_0080);
    expect_w0(32'hFFFF_FFFF, 32'h0, 1'b0, "R8 reset clears while asleep");

    // software reset while awake with access
    wake_up();
    expect_w0(32'h0000_001F, 32'h0000_000D, 1'b1, "R8 precondition awake");
    wr(1, 32'h0000_0080);
    expect_w0(32'hFFFF_FFFF, 32'h0, 1'b0, "R8 reset drops ready at once");
    addr = 4'd1; #1;
    n_checks++;
    if (rdata !== 32'h0) begin
      n_err++;
      $display("FAIL R8 offset 1 read: rdata=%h expected=%h", rdata, 32'h0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule